// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic core of a 16-bit fixed-point signal processor. It has a 32-bit accumulator, a 16-bit multiplicand register and a 32-bit product register. Each valid command runs in one clock. The command names an operation and supplies a 16-bit operand. An input shifter aligns that operand to the 32-bit ALU with a left shift of 0 to 16 places. A four-mode product shifter scales the product register before it is added to or subtracted from the accumulator.

Results are read through a 16-bit store path. An output shifter moves the accumulator left by 0 to 7 places and then selects the upper or lower half. The accumulator itself is never changed by that path. A carry flag and a sticky overflow flag report the outcome of additions and subtractions. An optional saturate mode clamps an overflowing result to the most positive or most negative 32-bit value. Decode of instructions and all memories belong to the surrounding processor.

Top module: `mac_datapath`

## Requirements
- R1: After reset, the accumulator, multiplicand register, product register, carry and overflow are all zero.
- R2: Opcodes 0 (add), 1 (subtract) and 2 (load) use the operand sign-extended to 32 bits and shifted left by `in_shift`. Any `in_shift` above 16 acts as 16. The new accumulator is visible after the next rising clock edge.
- R3: Add, subtract, product-add and product-subtract set carry to the unsigned carry out of bit 31. For the two subtractions, carry is 1 when the accumulator is not below the subtrahend, taken unsigned. All other commands leave carry unchanged.
- R4: Overflow is set by a signed 32-bit overflow of opcodes 0, 1, 6 or 7. It stays set until reset or opcode 12 clears it.
- R5: With `sat_en` = 1, an overflowing add or subtract writes 0x7FFFFFFF if the true result is positive, and 0x80000000 if it is negative. With `sat_en` = 0, the result wraps.
- R6: Opcodes 3 (AND), 4 (OR) and 5 (XOR) combine the accumulator with the operand. The operand is zero-extended and then shifted left by `in_shift`.
- R7: Opcode 8 loads the multiplicand register from the operand. Opcode 9 writes the signed 32-bit product of the multiplicand register and the operand into the product register. Neither opcode changes the accumulator.
- R8: Opcodes 6 (add product) and 7 (subtract product) use the product register scaled by `prod_mode`. The modes are 0 = unshifted, 1 = left by 1, 2 = left by 4, and 3 = arithmetic right by 6.
- R9: `store_data` equals bits 31:16 (if `store_hi` = 1) or bits 15:0 (if `store_hi` = 0) of the accumulator shifted left by `out_shift`. The accumulator is not modified.
- R10: Opcode 10 writes the operand into accumulator bits 31:16 and keeps bits 15:0. Opcode 11 writes bits 15:0 and keeps bits 31:16.
- R11: With `op_valid` = 0, or with an unused opcode (13 to 15), no register or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 4 | Operation select |
| operand | input | 16 | Data operand |
| in_shift | input | 5 | Input shifter left-shift amount |
| prod_mode | input | 2 | Product shifter mode |
| sat_en | input | 1 | Saturate on overflow |
| out_shift | input | 3 | Output shifter left-shift amount |
| store_hi | input | 1 | Store half select |
| store_data | output | 16 | Scaled accumulator half |
| carry | output | 1 | Carry flag |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The input shifter is swept over every amount from 0 to 20. The swept operands include sign-bit-set and all-ones values, which separates sign extension and the clamp at 16 from a plain shift. Additions and subtractions run over a grid of extreme accumulator values and extreme operands, with and without saturation. This grid separates wrap from clamp, carry from no-borrow, and a sticky flag from a per-operation one. Products of corner multiplicands are accumulated in all four product modes, which exposes logical versus arithmetic right shifts. The output shifter is swept over all eight amounts and both halves, and the accumulator is checked afterwards to show it was left intact.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_LOAD = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_PADD = 4'd6,
    OP_PSUB = 4'd7,
    OP_LDT  = 4'd8,
    OP_MUL  = 4'd9,
    OP_LDH  = 4'd10,
    OP_LDL  = 4'd11,
    OP_CLRV = 4'd12
  } mac_op_e;

  typedef enum logic [1:0] {
    PS_NONE = 2'd0,
    PS_L1   = 2'd1,
    PS_L4   = 2'd2,
    PS_R6   = 2'd3
  } pscale_e;

  typedef enum logic [2:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_PASS
  } alu_fn_e;
endpackage

// File: rtl/mac_in_shift.sv
`timescale 1ns/1ps
module mac_in_shift #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]             din,
  input  logic                      sext,
  input  logic [$clog2(DW+1)-1:0]   amt,
  output logic [2*DW-1:0]           dout
);
  localparam int SHW = $clog2(DW+1);
  localparam logic [SHW-1:0] AMT_MAX = SHW'(DW);

  logic [2*DW-1:0] ext;
  logic [SHW-1:0]  amt_c;

  always_comb begin
    ext   = sext ? {{DW{din[DW-1]}}, din} : {{DW{1'b0}}, din};
    amt_c = (amt > AMT_MAX) ? AMT_MAX : amt;
    dout  = ext << amt_c;
  end
endmodule

// File: rtl/mac_prod_shift.sv
`timescale 1ns/1ps
module mac_prod_shift
  import mac_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SH_A  = 1,
  parameter int SH_B  = 4,
  parameter int SH_R  = 6
) (
  input  logic [AW-1:0] prod,
  input  pscale_e       mode,
  output logic [AW-1:0] dout
);
  logic [AW-1:0] cand [4];

  always_comb begin
    cand[PS_NONE] = prod;
    cand[PS_L1]   = prod << SH_A;
    cand[PS_L4]   = prod << SH_B;
    cand[PS_R6]   = AW'($signed(prod) >>> SH_R);
    dout          = cand[mode];
  end
endmodule

// File: rtl/mac_alu.sv
`timescale 1ns/1ps
module mac_alu
  import mac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  alu_fn_e       fn,
  input  logic          sat_en,
  output logic [AW-1:0] res,
  output logic          carry_o,
  output logic          ovf_o
);
  localparam logic [AW-1:0] POS_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] NEG_MIN = {1'b1, {(AW-1){1'b0}}};

  logic          is_sub;
  logic [AW-1:0] b_eff;
  logic [AW:0]   sum;

  always_comb begin
    is_sub  = (fn == FN_SUB);
    b_eff   = is_sub ? ~b : b;
    sum     = {1'b0, a} + {1'b0, b_eff} + (AW+1)'(is_sub);
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    res     = b;
    unique case (fn)
      FN_ADD, FN_SUB: begin
        carry_o = sum[AW];
        ovf_o   = (a[AW-1] == b_eff[AW-1]) && (sum[AW-1] != a[AW-1]);
        if (ovf_o && sat_en) res = a[AW-1] ? NEG_MIN : POS_MAX;
        else                 res = sum[AW-1:0];
      end
      FN_AND:  res = a & b;
      FN_OR:   res = a | b;
      FN_XOR:  res = a ^ b;
      default: res = b;
    endcase
  end

  always_comb begin
    if (sat_en && ovf_o)
      assert_sat_clamp_R5: assert (res == POS_MAX || res == NEG_MIN)
        else $error("saturated result not at a limit");
  end
endmodule

// File: rtl/mac_out_shift.sv
`timescale 1ns/1ps
module mac_out_shift #(
  parameter int DW  = 16,
  parameter int OSW = 3
) (
  input  logic [2*DW-1:0] acc,
  input  logic [OSW-1:0]  amt,
  input  logic            hi,
  output logic [DW-1:0]   dout
);
  logic [2*DW-1:0] scaled;

  always_comb begin
    scaled = acc << amt;
    dout   = hi ? scaled[2*DW-1:DW] : scaled[DW-1:0];
  end
endmodule

// File: rtl/mac_datapath.sv
`timescale 1ns/1ps
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DW  = 16,
  parameter int OSW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [3:0]              op_code,
  input  logic [DW-1:0]           operand,
  input  logic [$clog2(DW+1)-1:0] in_shift,
  input  logic [1:0]              prod_mode,
  input  logic                    sat_en,
  input  logic [OSW-1:0]          out_shift,
  input  logic                    store_hi,
  output logic [DW-1:0]           store_data,
  output logic                    carry,
  output logic                    ovf
);
  localparam int AW = 2 * DW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  mac_op_e       op;
  logic [AW-1:0] acc_q, acc_d, preg_q, preg_d;
  logic [DW-1:0] treg_q, treg_d;
  logic          carry_q, carry_d, ovf_q, ovf_d;
  logic          acc_en, treg_en, preg_en, carry_en, ovf_en;

  logic          sext, use_prod, flag_op, clr_ovf;
  alu_fn_e       fn;
  logic [AW-1:0] opnd_sh, prod_sh, alu_b, alu_res;
  logic          alu_c, alu_v;

  assign op = mac_op_e'(op_code);

  mac_in_shift #(.DW(DW)) u_ish (
    .din(operand), .sext(sext), .amt(in_shift), .dout(opnd_sh)
  );

  mac_prod_shift #(.AW(AW)) u_psh (
    .prod(preg_q), .mode(pscale_e'(prod_mode)), .dout(prod_sh)
  );

  assign alu_b = use_prod ? prod_sh : opnd_sh;

  mac_alu #(.AW(AW)) u_alu (
    .a(acc_q), .b(alu_b), .fn(fn), .sat_en(sat_en),
    .res(alu_res), .carry_o(alu_c), .ovf_o(alu_v)
  );

  mac_out_shift #(.DW(DW), .OSW(OSW)) u_osh (
    .acc(acc_q), .amt(out_shift), .hi(store_hi), .dout(store_data)
  );

  // next-state decode
  always_comb begin
    fn       = FN_PASS;
    sext     = 1'b1;
    use_prod = 1'b0;
    flag_op  = 1'b0;
    clr_ovf  = 1'b0;
    acc_en   = 1'b0;
    treg_en  = 1'b0;
    preg_en  = 1'b0;
    acc_d    = alu_res;
    case (op)
      OP_ADD:  begin fn = FN_ADD; flag_op = 1'b1; acc_en = 1'b1; end
      OP_SUB:  begin fn = FN_SUB; flag_op = 1'b1; acc_en = 1'b1; end
      OP_LOAD: begin fn = FN_PASS; acc_en = 1'b1; end
      OP_AND:  begin fn = FN_AND; sext = 1'b0; acc_en = 1'b1; end
      OP_OR:   begin fn = FN_OR;  sext = 1'b0; acc_en = 1'b1; end
      OP_XOR:  begin fn = FN_XOR; sext = 1'b0; acc_en = 1'b1; end
      OP_PADD: begin fn = FN_ADD; use_prod = 1'b1; flag_op = 1'b1; acc_en = 1'b1; end
      OP_PSUB: begin fn = FN_SUB; use_prod = 1'b1; flag_op = 1'b1; acc_en = 1'b1; end
      OP_LDT:  treg_en = 1'b1;
      OP_MUL:  preg_en = 1'b1;
      OP_LDH:  begin acc_d = {operand, acc_q[DW-1:0]}; acc_en = 1'b1; end
      OP_LDL:  begin acc_d = {acc_q[AW-1:DW], operand}; acc_en = 1'b1; end
      OP_CLRV: clr_ovf = 1'b1;
      default: ;
    endcase
    acc_en   = acc_en  && op_valid;
    treg_en  = treg_en && op_valid;
    preg_en  = preg_en && op_valid;
    carry_en = flag_op && op_valid;
    ovf_en   = (flag_op || clr_ovf) && op_valid;
    treg_d   = operand;
    preg_d   = AW'($signed(treg_q) * $signed(operand));
    carry_d  = alu_c;
    ovf_d    = clr_ovf ? 1'b0 : (ovf_q | alu_v);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      acc_q   <= '0;
      treg_q  <= '0;
      preg_q  <= '0;
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (acc_en)   acc_q   <= acc_d;
      if (treg_en)  treg_q  <= treg_d;
      if (preg_en)  preg_q  <= preg_d;
      if (carry_en) carry_q <= carry_d;
      if (ovf_en)   ovf_q   <= ovf_d;
    end
  end

  assign carry = carry_q;
  assign ovf   = ovf_q;

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    !op_valid |=> $stable(acc_q) && $stable(treg_q) && $stable(preg_q)
                  && $stable(carry_q) && $stable(ovf_q))
    else $error("state moved without a command");

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    ovf_q && !(op_valid && op_code == 4'd12) |=> ovf_q)
    else $error("overflow flag dropped without clear");

  assert_treg_only_load_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    !(op_valid && op_code == 4'd8) |=> $stable(treg_q))
    else $error("multiplicand changed by another command");

  assert_mul_keeps_acc_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    op_valid && (op_code == 4'd8 || op_code == 4'd9) |=> $stable(acc_q))
    else $error("accumulator changed by multiply path");

  assert_carry_hold_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    !(op_valid && (op_code == 4'd0 || op_code == 4'd1 || op_code == 4'd6
                   || op_code == 4'd7)) |=> $stable(carry_q))
    else $error("carry changed by a non-arithmetic command");
endmodule

// File: tb/tb_mac_datapath.sv
`timescale 1ns/1ps
module tb_mac_datapath;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [15:0] operand;
  logic [4:0]  in_shift;
  logic [1:0]  prod_mode;
  logic        sat_en;
  logic [2:0]  out_shift;
  logic        store_hi;
  logic [15:0] store_data;
  logic        carry, ovf;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_acc, m_preg;
  logic [15:0] m_treg;
  logic        m_c, m_v;

  always #2.5 clk = ~clk;

  mac_datapath dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .in_shift(in_shift), .prod_mode(prod_mode),
    .sat_en(sat_en), .out_shift(out_shift), .store_hi(store_hi),
    .store_data(store_data), .carry(carry), .ovf(ovf)
  );

  function automatic logic [31:0] ish(logic [15:0] v, int s, bit sx);
    logic [31:0] e;
    int k;
    k = (s > 16) ? 16 : s;
    e = sx ? {{16{v[15]}}, v} : {16'h0000, v};
    return e << k;
  endfunction

  function automatic logic [31:0] pscale(logic [31:0] p, int m);
    longint x;
    x = longint'($signed(p));
    case (m)
      1:       x = x * 2;
      2:       x = x * 16;
      3:       x = x >>> 6;
      default: ;
    endcase
    return x[31:0];
  endfunction

  task automatic check_state(string tag);
    logic [15:0] hi, lo;
    out_shift = 3'd0;
    store_hi  = 1'b1;
    #0.4 hi = store_data;
    store_hi  = 1'b0;
    #0.4 lo = store_data;
    total++;
    if ({hi, lo} !== m_acc) begin
      bad++;
      $display("FAIL %s acc: actual=%h expected=%h", tag, {hi, lo}, m_acc);
    end
    total++;
    if (carry !== m_c || ovf !== m_v) begin
      bad++;
      $display("FAIL %s flags c/v: actual=%b%b expected=%b%b", tag, carry, ovf, m_c, m_v);
    end
  endtask

  task automatic model(int op, logic [15:0] d, int s, int pm, bit sat);
    logic [31:0] b;
    longint sa, sb, sr;
    bit sub, v;
    case (op)
      0, 1, 6, 7: begin
        b   = (op < 2) ? ish(d, s, 1'b1) : pscale(m_preg, pm);
        sub = (op == 1 || op == 7);
        sa  = longint'($signed(m_acc));
        sb  = longint'($signed(b));
        sr  = sub ? sa - sb : sa + sb;
        v   = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        if (sub) m_c = (m_acc >= b);
        else     m_c = (({32'h0, m_acc} + {32'h0, b}) >> 32) != 0;
        m_v   = m_v | v;
        m_acc = (sat && v) ? ((sr > 0) ? 32'h7FFFFFFF : 32'h80000000) : sr[31:0];
      end
      2:  m_acc = ish(d, s, 1'b1);
      3:  m_acc = m_acc & ish(d, s, 1'b0);
      4:  m_acc = m_acc | ish(d, s, 1'b0);
      5:  m_acc = m_acc ^ ish(d, s, 1'b0);
      8:  m_treg = d;
      9:  begin
        sr = longint'($signed(m_treg)) * longint'($signed(d));
        m_preg = sr[31:0];
      end
      10: m_acc = {d, m_acc[15:0]};
      11: m_acc = {m_acc[31:16], d};
      12: m_v = 1'b0;
      default: ;
    endcase
  endtask

  task automatic do_op(int op, logic [15:0] d, int s, int pm, bit sat, string tag);
    @(negedge clk);
    op_valid  = 1'b1;
    op_code   = 4'(op);
    operand   = d;
    in_shift  = 5'(s);
    prod_mode = 2'(pm);
    sat_en    = sat;
    @(negedge clk);
    op_valid = 1'b0;
    model(op, d, s, pm, sat);
    check_state(tag);
  endtask

  task automatic set_acc(logic [31:0] v);
    do_op(10, v[31:16], 0, 0, 1'b0, "R10 high-half load");
    do_op(11, v[15:0], 0, 0, 1'b0, "R10 low-half load");
  endtask

  initial begin
    #750000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] ops_a [5];
    logic [31:0] bases [5];
    logic [15:0] ops_b [4];
    logic [15:0] tv [4];
    logic [15:0] mv [3];
    logic [31:0] ob [2];
    logic [15:0] got, expd;
    logic [31:0] sh;
    ops_a = '{16'h0001, 16'h8000, 16'h7FFF, 16'hA5C3, 16'hFFFF};
    bases = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h12345678};
    ops_b = '{16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF};
    tv    = '{16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    mv    = '{16'h8000, 16'h0003, 16'hFEDC};
    ob    = '{32'h89ABCDEF, 32'h40018003};

    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; operand = '0;
    in_shift = '0; prod_mode = '0; sat_en = 1'b0; out_shift = '0; store_hi = 1'b0;
    m_acc = '0; m_preg = '0; m_treg = '0; m_c = 1'b0; m_v = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_state("R1 reset state");
    // R1: product register zero -> add-product leaves zero
    do_op(6, 16'h0, 0, 0, 1'b0, "R1 product register cleared");

    // R2: load through input shifter, all amounts incl. above 16
    for (int i = 0; i < 5; i++)
      for (int s = 0; s <= 20; s++)
        do_op(2, ops_a[i], s, 0, 1'b0, "R2 load shift");

    // R3 R4 R5: add/sub grid
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 4; j++)
        for (int o = 0; o < 2; o++)
          for (int sat = 0; sat < 2; sat++)
            for (int sh16 = 0; sh16 < 2; sh16++) begin
              do_op(12, 16'h0, 0, 0, 1'b0, "R4 overflow clear");
              set_acc(bases[i]);
              do_op(o, ops_b[j], sh16 * 16, 0, sat[0], "R3 R4 R5 add/sub");
            end

    // R4: sticky across a clean add, then cleared
    set_acc(32'h7FFFFFFF);
    do_op(0, 16'h0001, 0, 0, 1'b0, "R4 overflow set");
    do_op(0, 16'h0001, 0, 0, 1'b0, "R4 overflow stays set");
    do_op(12, 16'h0, 0, 0, 1'b0, "R4 overflow cleared");

    // R6: boolean ops with zero extension
    for (int op = 3; op <= 5; op++)
      for (int s = 0; s <= 16; s += 4) begin
        set_acc(32'hF0F03C3C);
        do_op(op, 16'h9A5F, s, 0, 1'b0, "R6 boolean op");
      end

    // R7 R8: multiply and scaled product accumulate
    for (int t = 0; t < 4; t++)
      for (int m = 0; m < 3; m++)
        for (int pm = 0; pm < 4; pm++)
          for (int o = 6; o <= 7; o++) begin
            do_op(12, 16'h0, 0, 0, 1'b0, "R4 overflow clear");
            set_acc(32'h00001000);
            do_op(8, tv[t], 0, 0, 1'b0, "R7 multiplicand load keeps acc");
            do_op(9, mv[m], 0, 0, 1'b0, "R7 multiply keeps acc");
            do_op(o, 16'h0, 0, pm, 1'b0, "R8 product mode accumulate");
          end

    // R9: output shifter over all amounts and halves
    for (int b = 0; b < 2; b++) begin
      set_acc(ob[b]);
      for (int k = 0; k < 8; k++)
        for (int h = 0; h < 2; h++) begin
          @(negedge clk);
          out_shift = 3'(k);
          store_hi  = h[0];
          #0.4 got  = store_data;
          sh   = m_acc << k;
          expd = h[0] ? sh[31:16] : sh[15:0];
          total++;
          if (got !== expd) begin
            bad++;
            $display("FAIL R9 store k=%0d hi=%0d: actual=%h expected=%h", k, h, got, expd);
          end
        end
      @(negedge clk);
      check_state("R9 accumulator unchanged by output shift");
    end

    // R11: strobe low, and unused opcodes
    set_acc(32'h7FFFFFFF);
    @(negedge clk);
    op_valid = 1'b0; op_code = 4'd0; operand = 16'h0001; in_shift = '0;
    @(negedge clk);
    check_state("R11 idle command ignored");
    for (int op = 13; op <= 15; op++)
      do_op(op, 16'hFFFF, 3, 1, 1'b0, "R11 unused opcode");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule